// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel

This block is a single DMA channel that fetches a block of 32-bit words from memory and sends them out as a valid/ready stream. Software programs a start address and a beat count through a small register port, then sets the go bit in the control register. From then on the channel issues word reads at ascending addresses and buffers the returned data in a small FIFO. It hands the words to the downstream consumer in order and flags the final beat. When the final beat is accepted, the channel counts one completed transfer and pulses a completion output.

The memory port is an enable and address in one cycle, with data returned some cycles later under a valid strobe. Returns come back in request order and cannot be refused. The channel therefore limits the number of reads it issues, so that every read in flight already has a FIFO slot waiting for it.

On the stream side, a beat is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the beat on offer (data and last flag) is held unchanged. The channel never withdraws a beat it has offered. The consumer may hold `out_ready` low for any length of time, and the channel then stops issuing reads once its buffer is committed.

Top module: `m2s_dma`

## Requirements
- R1: Register offsets decode as follows, and only word-aligned offsets decode: 0x0 is the start address, 0x4 is the beat count and 0x8 is control. Address bits 1:0 are stored as zero. A read returns its data with `reg_rd_valid` one cycle after `reg_rd_en`. Offset 0x0 reads as the next address to fetch, 0x4 as the number of beats not yet requested, and 0x8 as the run bit in bit 0.
- R2: Writing control with bit 0 set while idle, with a nonzero count, starts a transfer, and `busy` is high in the next cycle. Writing control with bit 0 clear starts nothing.
- R3: A transfer of N beats issues exactly N memory reads. The first read goes to the programmed address and each later read goes to the previous address plus 4.
- R4: The stream carries exactly N beats, in address order, each carrying the word memory returned for that address.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold. No beat is transferred without `out_ready`.
- R6: `out_last` is high on the N-th beat of a transfer and on no other beat.
- R7: On the edge that accepts the final beat, `busy` falls and control bit 0 clears. In the next cycle `done_count` has risen by exactly one and `done_pulse` is high for that one cycle.
- R8: A start with a count of zero issues no reads and no beats, and leaves `busy` low. It still raises `done_count` by one and pulses `done_pulse`.
- R9: Register writes of any kind are ignored while `busy` is high, and that includes a second start.
- R10: The sum of reads in flight and words buffered never exceeds FIFO_DEPTH. With `out_ready` held low, a transfer issues exactly FIFO_DEPTH reads and then stops.
- R11: After reset, `busy`, `out_valid`, `mem_rd_en`, `done_pulse` and `done_count` are zero, and all three registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data |
| reg_rd_valid | output | 1 | Read data valid, one cycle after reg_rd_en |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory byte address of the request |
| mem_rd_data | input | DATA_W | Returned memory word |
| mem_rd_valid | input | 1 | Returned word valid (in request order) |
| out_valid | output | 1 | Stream beat on offer |
| out_data | output | DATA_W | Stream beat data |
| out_last | output | 1 | Final beat of the transfer |
| out_ready | input | 1 | Downstream accepts the beat |
| busy | output | 1 | Transfer in progress |
| done_count | output | DONE_W | Completed transfers, wrapping |
| done_pulse | output | 1 | One-cycle pulse per completed transfer |

## Verification
Transfers run with the consumer always ready, ready on alternate cycles, and ready two cycles out of three. Together these separate full-rate streaming from the hold behaviour under stalls, and show that data and the last flag stay aligned to their addresses whatever the stall pattern. Lengths of 1, 5, 9 and 16 beats at different base addresses separate a correct last-beat marker from an off-by-one. They also confirm that the address step and the final address readback follow the length. A consumer that is never ready reveals the read throttle, and register writes made during that stall show whether a busy channel keeps its program. A zero-length start and a control write with bit 0 clear separate the empty-transfer completion from a start that should not happen.

// File: rtl/m2s_dma_pkg.sv
package m2s_dma_pkg;

  localparam int REG_OFF_W   = 4;
  localparam int REG_DW      = 32;
  localparam int WORD_BYTES  = 4;
  localparam int CTRL_GO_BIT = 0;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Word-aligned offsets only; anything else selects nothing.
  function automatic reg_sel_e decode_sel(input logic [REG_OFF_W-1:0] off);
    if (off[1:0] != 2'b00) return SEL_NONE;
    case (off[3:2])
      2'd0:    return SEL_ADDR;
      2'd1:    return SEL_COUNT;
      2'd2:    return SEL_CTRL;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/m2s_dma_regs.sv
module m2s_dma_regs
  import m2s_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [REG_OFF_W-1:0] reg_addr,
  input  logic [REG_DW-1:0]    reg_wr_data,
  output logic [REG_DW-1:0]    reg_rd_data,
  output logic                 reg_rd_valid,
  input  logic                 issue_i,
  input  logic                 finish_i,
  output logic [ADDR_W-1:0]    cur_addr_o,
  output logic [CNT_W-1:0]     remaining_o,
  output logic                 run_o,
  output logic                 start_o,
  output logic                 start_empty_o,
  output logic [CNT_W-1:0]     start_count_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  logic              go_req;
  reg_sel_e          sel;

  assign sel    = decode_sel(reg_addr);
  assign go_req = reg_wr_en && !run_q && (sel == SEL_CTRL) && reg_wr_data[CTRL_GO_BIT];

  assign start_o       = go_req && (cnt_q != '0);
  assign start_empty_o = go_req && (cnt_q == '0);
  assign start_count_o = cnt_q;
  assign cur_addr_o    = addr_q;
  assign remaining_o   = cnt_q;
  assign run_o         = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      // Programming is only accepted while idle.
      if (reg_wr_en && !run_q) begin
        if (sel == SEL_ADDR)  addr_q <= {reg_wr_data[ADDR_W-1:2], 2'b00};
        if (sel == SEL_COUNT) cnt_q  <= reg_wr_data[CNT_W-1:0];
      end
      if (start_o)       run_q <= 1'b1;
      else if (finish_i) run_q <= 1'b0;
      // Issue only happens while running, so it never meets a write.
      if (issue_i) begin
        addr_q <= addr_q + ADDR_W'(WORD_BYTES);
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rd_valid <= 1'b0;
      reg_rd_data  <= '0;
    end else begin
      reg_rd_valid <= reg_rd_en;
      if (reg_rd_en) begin
        case (sel)
          SEL_ADDR:  reg_rd_data <= REG_DW'(addr_q);
          SEL_COUNT: reg_rd_data <= REG_DW'(cnt_q);
          SEL_CTRL:  reg_rd_data <= {{(REG_DW-1){1'b0}}, run_q};
          default:   reg_rd_data <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/m2s_dma_fifo.sv
module m2s_dma_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [WIDTH-1:0]           push_data_i,
  input  logic                       pop_i,
  output logic [WIDTH-1:0]           head_o,
  output logic                       not_empty_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign head_o      = mem[rd_ptr];
  assign not_empty_o = (occ_q != '0);
  assign count_o     = occ_q;

endmodule

// File: rtl/m2s_dma_track.sv
module m2s_dma_track #(
  parameter int CNT_W  = 16,
  parameter int DONE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_empty_i,
  input  logic [CNT_W-1:0]  start_count_i,
  input  logic              beat_i,
  output logic              last_o,
  output logic              finish_o,
  output logic [DONE_W-1:0] done_count_o,
  output logic              done_pulse_o
);

  logic [CNT_W-1:0]  left_q;
  logic [DONE_W-1:0] done_q;
  logic              pulse_q;
  logic              complete;

  // Beats still to be accepted; the head beat is the last when one remains.
  assign last_o   = (left_q == CNT_W'(1));
  assign finish_o = beat_i && last_o;
  assign complete = finish_o || start_empty_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      done_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (start_i)     left_q <= start_count_i;
      else if (beat_i) left_q <= left_q - 1'b1;
      pulse_q <= complete;
      if (complete) done_q <= done_q + 1'b1;
    end
  end

  assign done_count_o = done_q;
  assign done_pulse_o = pulse_q;

endmodule

// File: rtl/m2s_dma.sv
module m2s_dma
  import m2s_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DONE_W     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [REG_OFF_W-1:0] reg_addr,
  input  logic [REG_DW-1:0]    reg_wr_data,
  output logic [REG_DW-1:0]    reg_rd_data,
  output logic                 reg_rd_valid,
  output logic                 mem_rd_en,
  output logic [ADDR_W-1:0]    mem_rd_addr,
  input  logic [DATA_W-1:0]    mem_rd_data,
  input  logic                 mem_rd_valid,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_last,
  input  logic                 out_ready,
  output logic                 busy,
  output logic [DONE_W-1:0]    done_count,
  output logic                 done_pulse
);

  localparam int OCC_W = $clog2(FIFO_DEPTH + 1);
  localparam int SUM_W = OCC_W + 1;

  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  remaining, start_count;
  logic              run, start, start_empty;
  logic [OCC_W-1:0]  inflight_q, fifo_occ;
  logic              fifo_ne, beat, last, finish, credit_ok;

  m2s_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid),
    .issue_i(mem_rd_en), .finish_i(finish),
    .cur_addr_o(cur_addr), .remaining_o(remaining), .run_o(run),
    .start_o(start), .start_empty_o(start_empty), .start_count_o(start_count)
  );

  // A read is only issued when a FIFO slot is already reserved for it,
  // because the memory cannot be stalled on its return path.
  assign credit_ok = (SUM_W'(inflight_q) + SUM_W'(fifo_occ)) < SUM_W'(FIFO_DEPTH);
  assign mem_rd_en   = run && (remaining != '0) && credit_ok;
  assign mem_rd_addr = cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight_q <= '0;
    end else begin
      case ({mem_rd_en, mem_rd_valid})
        2'b10:   inflight_q <= inflight_q + 1'b1;
        2'b01:   inflight_q <= inflight_q - 1'b1;
        default: inflight_q <= inflight_q;
      endcase
    end
  end

  m2s_dma_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(mem_rd_valid), .push_data_i(mem_rd_data),
    .pop_i(beat), .head_o(out_data),
    .not_empty_o(fifo_ne), .count_o(fifo_occ)
  );

  assign out_valid = fifo_ne;
  assign beat      = out_valid && out_ready;
  assign out_last  = fifo_ne && last;
  assign busy      = run;

  m2s_dma_track #(.CNT_W(CNT_W), .DONE_W(DONE_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .start_empty_i(start_empty), .start_count_i(start_count),
    .beat_i(beat), .last_o(last), .finish_o(finish),
    .done_count_o(done_count), .done_pulse_o(done_pulse)
  );

endmodule

// File: rtl/m2s_dma_chk.sv
module m2s_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DONE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              out_ready,
  input logic [DONE_W-1:0] done_count,
  input logic              done_pulse
);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && $past(mem_rd_en) |-> mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(4));

  // R4
  beat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R7
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !busy && done_pulse);

  // R7
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !busy);

  // R7
  done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_count != $past(done_count) |-> done_count == DONE_W'($past(done_count) + 1'b1));

endmodule

bind m2s_dma m2s_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DONE_W(DONE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
  .done_count(done_count), .done_pulse(done_pulse)
);

// File: tb/m2s_dma_bench.sv
`timescale 1ns/1ps
module m2s_dma_bench;

  localparam int DEPTH   = 4;
  localparam int MEM_LAT = 3;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] cnt;
    logic [1:0]  pat;   // 0 always ready, 1 alternate, 2 two of three
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0100, 16'd16, 2'd0},
    '{32'h0000_2000, 16'd5,  2'd1},
    '{32'h0000_0040, 16'd1,  2'd2},
    '{32'h0000_FFC0, 16'd9,  2'd2},
    '{32'h0001_0300, 16'd16, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, reg_rd_en;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic        reg_rd_valid;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        mem_rd_valid;
  logic        out_valid, out_last, out_ready;
  logic [31:0] out_data;
  logic        busy;
  logic [15:0] done_count;
  logic        done_pulse;

  always #2.5 clk = ~clk;

  m2s_dma #(.FIFO_DEPTH(DEPTH)) u_m2s_dma (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .busy(busy), .done_count(done_count), .done_pulse(done_pulse)
  );

  function automatic logic [31:0] memword(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'hC35A_9600;
  endfunction

  // Fixed-latency, in-order memory model.
  logic        lat_v [MEM_LAT];
  logic [31:0] lat_a [MEM_LAT];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_LAT; i++) begin lat_v[i] <= 1'b0; lat_a[i] <= '0; end
    end else begin
      lat_v[0] <= mem_rd_en;
      lat_a[0] <= mem_rd_addr;
      for (int i = 1; i < MEM_LAT; i++) begin lat_v[i] <= lat_v[i-1]; lat_a[i] <= lat_a[i-1]; end
    end
  end
  assign mem_rd_valid = lat_v[MEM_LAT-1];
  assign mem_rd_data  = memword(lat_a[MEM_LAT-1]);

  int n_checks = 0, n_fail = 0, cyc = 0;
  int n_reads, n_beats, x_cnt, exp_done = 0;
  logic [31:0] x_base, rd_val;
  bit finished = 1'b0;

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] off, input logic [31:0] val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = off; reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = '0; reg_wr_data = '0;
  endtask

  task automatic reg_read(input logic [3:0] off, output logic [31:0] val);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = off;
    @(negedge clk);
    reg_rd_en = 1'b0; reg_addr = '0;
    check_eq("R1", "read valid strobe", 32'(reg_rd_valid), 32'd1);
    val = reg_rd_data;
  endtask

  // Observe one cycle at the negedge, then advance to the next negedge.
  task automatic step(input int pat);
    case (pat)
      0:       out_ready = 1'b1;
      1:       out_ready = (cyc % 2) == 1;
      2:       out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
    if (mem_rd_en) begin
      check_eq("R3", "read address", mem_rd_addr, x_base + 32'(n_reads * 4));
      n_reads++;
    end
    if (out_valid && out_ready) begin
      check_eq("R4", "beat data", out_data, memword(x_base + 32'(n_beats * 4)));
      check_eq("R6", "last flag", 32'(out_last), 32'(n_beats == x_cnt - 1));
      n_beats++;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic begin_xfer(input logic [31:0] base, input int cnt);
    out_ready = 1'b0;
    x_base = base; x_cnt = cnt; n_reads = 0; n_beats = 0;
    reg_write(4'h0, base);
    reg_write(4'h4, 32'(cnt));
    reg_write(4'h8, 32'd1);
    check_eq("R2", "busy after start", 32'(busy), 32'd1);
  endtask

  task automatic drain(input int pat);
    int guard = 0;
    while (n_beats < x_cnt && guard < 3000) begin
      step(pat);
      guard++;
    end
    check_eq("R4", "beats delivered", 32'(n_beats), 32'(x_cnt));
  endtask

  task automatic finish_checks();
    logic [31:0] v;
    check_eq("R7", "busy after last beat", 32'(busy), 32'd0);
    check_eq("R7", "completion pulse", 32'(done_pulse), 32'd1);
    check_eq("R7", "completion count", 32'(done_count), 32'(exp_done));
    check_eq("R3", "reads issued", 32'(n_reads), 32'(x_cnt));
    check_eq("R4", "no extra beat", 32'(out_valid), 32'd0);
    out_ready = 1'b0;
    reg_read(4'h0, v); check_eq("R1", "final address", v, x_base + 32'(x_cnt * 4));
    reg_read(4'h4, v); check_eq("R1", "remaining count", v, 32'd0);
    reg_read(4'h8, v); check_eq("R7", "control bit cleared", v, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0;
    reg_wr_data = '0; out_ready = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R11)
    check_eq("R11", "busy", 32'(busy), 32'd0);
    check_eq("R11", "out_valid", 32'(out_valid), 32'd0);
    check_eq("R11", "mem_rd_en", 32'(mem_rd_en), 32'd0);
    check_eq("R11", "done_pulse", 32'(done_pulse), 32'd0);
    check_eq("R11", "done_count", 32'(done_count), 32'd0);
    reg_read(4'h0, rd_val); check_eq("R11", "address reg", rd_val, 32'd0);
    reg_read(4'h4, rd_val); check_eq("R11", "count reg", rd_val, 32'd0);
    reg_read(4'h8, rd_val); check_eq("R11", "control reg", rd_val, 32'd0);

    // Address low bits dropped; misaligned offset decodes to nothing (R1)
    reg_write(4'h0, 32'h0000_0107);
    reg_read(4'h0, rd_val); check_eq("R1", "aligned address", rd_val, 32'h0000_0104);
    reg_write(4'h5, 32'd7);
    reg_read(4'h4, rd_val); check_eq("R1", "misaligned offset ignored", rd_val, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      exp_done++;
      begin_xfer(VECS[i].base, int'(VECS[i].cnt));
      drain(int'(VECS[i].pat));
      finish_checks();
    end

    // Stalled consumer: read throttle (R10), hold (R5), writes ignored (R9)
    exp_done++;
    begin_xfer(32'h0000_4000, 8);
    repeat (20) step(3);
    check_eq("R10", "reads while stalled", 32'(n_reads), 32'(DEPTH));
    check_eq("R5", "no beat without ready", 32'(n_beats), 32'd0);
    check_eq("R5", "beat still offered", 32'(out_valid), 32'd1);
    reg_write(4'h0, 32'h0000_9000);
    reg_write(4'h4, 32'd3);
    reg_write(4'h8, 32'd1);
    reg_read(4'h0, rd_val); check_eq("R9", "address kept", rd_val, 32'h0000_4000 + 32'(DEPTH * 4));
    reg_read(4'h4, rd_val); check_eq("R9", "count kept", rd_val, 32'(8 - DEPTH));
    reg_read(4'h8, rd_val); check_eq("R1", "run bit while busy", rd_val, 32'd1);
    drain(0);
    finish_checks();

    // Zero-length start (R8)
    reg_write(4'h4, 32'd0);
    reg_write(4'h8, 32'd1);
    exp_done++;
    check_eq("R8", "pulse on empty start", 32'(done_pulse), 32'd1);
    check_eq("R8", "busy stays low", 32'(busy), 32'd0);
    check_eq("R8", "count on empty start", 32'(done_count), 32'(exp_done));
    out_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      check_eq("R8", "no read or beat", 32'(mem_rd_en | out_valid), 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b0;

    // Control write with bit 0 clear starts nothing (R2)
    reg_write(4'h4, 32'd5);
    reg_write(4'h8, 32'd0);
    repeat (3) @(negedge clk);
    check_eq("R2", "no start on bit0 clear", 32'(busy | mem_rd_en), 32'd0);
    check_eq("R2", "count unchanged", 32'(done_count), 32'(exp_done));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #750000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule